// File: doc/BRIEF.md
# Software-Reloaded Address Translation Buffer Unit

This block translates 32-bit effective addresses into 32-bit physical addresses. It has two small on-chip translation buffers: one serves instruction fetches and the other serves data loads and stores. For each request the caller supplies the segment descriptor that was already selected upstream. That descriptor is a 24-bit segment identifier plus a direct-segment flag. The segment identifier and the 16-bit page index taken from the effective address form a 40-bit tag. The tag, together with the 12-bit offset inside a 4 KB page, makes up the 52-bit virtual address. The tag is compared against every entry of the buffer that matches the access kind.

The block has no hardware table walker. A miss reports one of three miss codes and captures the failing instruction address and effective address for the handler. A hit that fails its protection check also reports a code and captures those addresses, and so does a store to a page whose changed bit is still clear. Software then writes the entry through the reload port and retries the access. A global invalidate input clears both buffers. Every response appears exactly one clock after its request.

Top module: `xlt_tlb_unit`

## Requirements
- R1: After reset the response valid flag, exception code, physical address and both fault registers are zero, and every entry of both buffers is invalid, so the first translated lookup misses.
- R2: A request with `req_direct` high performs no lookup. It returns `rsp_bypass`=1, exception code 0 and address 0, and leaves the fault registers unchanged.
- R3: A request presented in cycle N is answered in cycle N+1. On a hit with no exception, `rsp_pa` = {entry page number, `req_ea[11:0]`} and the code is 0. Whenever the code is non-zero, `rsp_pa` is 0.
- R4: Fetches (kind 0) search only the instruction buffer (reload side 0). Loads (kind 1) and stores (kind 2) search only the data buffer (reload side 1). Kind 3 behaves as a load.
- R5: The tag is {`req_vsid`, `req_ea[27:12]`}, so a difference in either part is a miss. `req_ea[31:28]` takes no part in the compare. A miss gives code 1 for a fetch, 2 for a load and 3 for a store.
- R6: A reload takes effect at the clock edge that samples it. A request in the same cycle sees the old contents, and a retry in any later cycle hits.
- R7: Protection field encoding: 00 allows no access, 01 allows fetch and load, 10 allows load and store, 11 allows everything. A disallowed fetch gives code 4, and a disallowed load or store gives code 5.
- R8: A store that hits a permitted entry whose changed bit is 0 gives code 6. Fetches and loads ignore the changed bit.
- R9: Only one code is reported per access. The priority is miss, then protection, then changed bit.
- R10: When a response carries a non-zero code, `fault_pc` and `fault_ea` hold that request's `req_pc` and `req_ea` in the same cycle. At all other times they keep their values.
- R11: `inval_all` clears every valid bit in both buffers at the next edge. A reload in the same cycle still leaves its own entry valid.
- R12: A reload to an index replaces whatever was there, so the old tag no longer hits. When several entries match, the lowest index supplies the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_kind | input | 2 | 0 fetch, 1 load, 2 store, 3 treated as load |
| req_direct | input | 1 | Direct-segment flag from the descriptor; skips translation |
| req_vsid | input | 24 | Segment identifier from the descriptor |
| req_ea | input | 32 | Effective address |
| req_pc | input | 32 | Address of the issuing instruction |
| rld_valid | input | 1 | Write one buffer entry |
| rld_side | input | 1 | 0 instruction buffer, 1 data buffer |
| rld_idx | input | 4 | Entry index to write |
| rld_vsid | input | 24 | Segment identifier part of the new tag |
| rld_pidx | input | 16 | Page index part of the new tag |
| rld_ppn | input | 20 | Physical page number |
| rld_prot | input | 2 | Protection field |
| rld_chg | input | 1 | Changed bit |
| inval_all | input | 1 | Clear all valid bits in both buffers |
| rsp_valid | output | 1 | Response for last cycle's request |
| rsp_bypass | output | 1 | Request skipped translation |
| rsp_exc | output | 3 | Exception code 0..6 |
| rsp_pa | output | 32 | Physical address |
| fault_pc | output | 32 | Captured instruction address of last exception |
| fault_ea | output | 32 | Captured effective address of last exception |

## Verification
The bench targets the cases that are easiest to get wrong:

- Tags that differ only in the segment identifier or only in the page index. A design that compares a truncated tag would return a false hit.
- A reload in the same cycle as its request. A design that bypasses written data to the lookup would hit one cycle early.
- A fetch to a page that exists only in the data buffer. A shared or swapped buffer would hit where it should miss.
- A store to a read-only page whose changed bit is clear. A wrong priority would report the changed-bit trap instead of the protection code.
- An invalidate combined with a reload. Getting the order wrong would lose the freshly written entry.
- Fault-register capture. A design that captures on every response would overwrite the handler's address on the next clean access.

// File: rtl/xlt_pkg.sv
package xlt_pkg;

    localparam int VSID_W = 24;
    localparam int PIDX_W = 16;
    localparam int OFF_W  = 12;
    localparam int SEL_W  = 4;
    localparam int PPN_W  = 20;
    localparam int PROT_W = 2;
    localparam int TAG_W  = VSID_W + PIDX_W;
    localparam int EA_W   = SEL_W + PIDX_W + OFF_W;
    localparam int PA_W   = PPN_W + OFF_W;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic [2:0] {
        EXC_NONE  = 3'd0,
        EXC_IMISS = 3'd1,
        EXC_LMISS = 3'd2,
        EXC_SMISS = 3'd3,
        EXC_IPROT = 3'd4,
        EXC_DPROT = 3'd5,
        EXC_CHG   = 3'd6
    } exc_e;

    typedef struct packed {
        logic              valid;
        logic [TAG_W-1:0]  tag;
        logic [PPN_W-1:0]  ppn;
        logic [PROT_W-1:0] prot;
        logic              chg;
    } tlb_ent_t;

    // Protection field: 00 none, 01 fetch+load, 10 load+store, 11 all.
    function automatic logic prot_allows(input logic [PROT_W-1:0] prot,
                                         input acc_kind_e kind);
        logic ok;
        unique case (kind)
            ACC_FETCH: ok = prot[0];
            ACC_STORE: ok = prot[1];
            default:   ok = (prot != '0);
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/xlt_tlb_bank.sv
module xlt_tlb_bank
    import xlt_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  tlb_ent_t         wr_ent,
    input  logic             inval_all,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    output tlb_ent_t         lk_ent
);

    typedef struct packed {
        tlb_ent_t [ENTRIES-1:0] ents;
    } bank_st_t;

    bank_st_t st_d, st_q;
    logic [ENTRIES-1:0] match;
    logic [IDX_W-1:0]   sel;

    // Next state: invalidate first, then the reload write wins for its slot.
    always_comb begin
        st_d = st_q;
        if (inval_all) begin
            for (int i = 0; i < ENTRIES; i++) begin
                st_d.ents[i].valid = 1'b0;
            end
        end
        if (wr_en) begin
            st_d.ents[wr_idx] = wr_ent;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Fully associative compare, one comparator per entry.
    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
            assign match[g] = st_q.ents[g].valid && (st_q.ents[g].tag == lk_tag);
        end
    endgenerate

    // Lowest matching index supplies the entry.
    always_comb begin
        sel = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                sel = IDX_W'(i);
            end
        end
    end

    assign lk_hit = |match;
    assign lk_ent = st_q.ents[sel];

endmodule

// File: rtl/xlt_access_judge.sv
module xlt_access_judge
    import xlt_pkg::*;
(
    input  acc_kind_e         kind,
    input  logic              hit,
    input  logic [PROT_W-1:0] prot,
    input  logic              chg,
    output exc_e              code
);

    // Priority: miss, then protection, then changed-bit trap.
    always_comb begin
        code = EXC_NONE;
        if (!hit) begin
            unique case (kind)
                ACC_FETCH: code = EXC_IMISS;
                ACC_STORE: code = EXC_SMISS;
                default:   code = EXC_LMISS;
            endcase
        end else if (!prot_allows(prot, kind)) begin
            code = (kind == ACC_FETCH) ? EXC_IPROT : EXC_DPROT;
        end else if ((kind == ACC_STORE) && !chg) begin
            code = EXC_CHG;
        end
    end

endmodule

// File: rtl/xlt_fault_capture.sv
module xlt_fault_capture
    import xlt_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cap_en,
    input  logic [EA_W-1:0] cap_pc,
    input  logic [EA_W-1:0] cap_ea,
    output logic [EA_W-1:0] fault_pc,
    output logic [EA_W-1:0] fault_ea
);

    typedef struct packed {
        logic [EA_W-1:0] pc;
        logic [EA_W-1:0] ea;
    } cap_st_t;

    cap_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cap_en) begin
            st_d.pc = cap_pc;
            st_d.ea = cap_ea;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fault_pc = st_q.pc;
    assign fault_ea = st_q.ea;

endmodule

// File: rtl/xlt_tlb_unit.sv
module xlt_tlb_unit
    import xlt_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int SIDES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic              req_direct,
    input  logic [VSID_W-1:0] req_vsid,
    input  logic [EA_W-1:0]   req_ea,
    input  logic [EA_W-1:0]   req_pc,
    input  logic              rld_valid,
    input  logic              rld_side,
    input  logic [IDX_W-1:0]  rld_idx,
    input  logic [VSID_W-1:0] rld_vsid,
    input  logic [PIDX_W-1:0] rld_pidx,
    input  logic [PPN_W-1:0]  rld_ppn,
    input  logic [PROT_W-1:0] rld_prot,
    input  logic              rld_chg,
    input  logic              inval_all,
    output logic              rsp_valid,
    output logic              rsp_bypass,
    output logic [2:0]        rsp_exc,
    output logic [PA_W-1:0]   rsp_pa,
    output logic [EA_W-1:0]   fault_pc,
    output logic [EA_W-1:0]   fault_ea
);

    typedef struct packed {
        logic            valid;
        logic            bypass;
        exc_e            exc;
        logic [PA_W-1:0] pa;
    } rsp_st_t;

    rsp_st_t rsp_d, rsp_q;

    acc_kind_e        kind;
    logic [TAG_W-1:0] lk_tag;
    tlb_ent_t         new_ent;
    logic             side_sel;
    logic [SIDES-1:0] bank_hit;
    tlb_ent_t         bank_ent [SIDES];
    logic             sel_hit;
    tlb_ent_t         sel_ent;
    exc_e             judge_code;

    assign kind     = acc_kind_e'(req_kind);
    assign lk_tag   = {req_vsid, req_ea[OFF_W+PIDX_W-1:OFF_W]};
    assign side_sel = (kind != ACC_FETCH);

    always_comb begin
        new_ent       = '0;
        new_ent.valid = 1'b1;
        new_ent.tag   = {rld_vsid, rld_pidx};
        new_ent.ppn   = rld_ppn;
        new_ent.prot  = rld_prot;
        new_ent.chg   = rld_chg;
    end

    // One buffer per side: 0 instruction, 1 data.
    generate
        for (genvar s = 0; s < SIDES; s++) begin : g_bank
            xlt_tlb_bank #(.ENTRIES(ENTRIES)) u_bank (
                .clk       (clk),
                .rst_n     (rst_n),
                .wr_en     (rld_valid && (rld_side == 1'(s))),
                .wr_idx    (rld_idx),
                .wr_ent    (new_ent),
                .inval_all (inval_all),
                .lk_tag    (lk_tag),
                .lk_hit    (bank_hit[s]),
                .lk_ent    (bank_ent[s])
            );
        end
    endgenerate

    assign sel_hit = bank_hit[side_sel];
    assign sel_ent = bank_ent[side_sel];

    xlt_access_judge u_judge (
        .kind (kind),
        .hit  (sel_hit),
        .prot (sel_ent.prot),
        .chg  (sel_ent.chg),
        .code (judge_code)
    );

    always_comb begin
        rsp_d = '0;
        if (req_valid) begin
            rsp_d.valid = 1'b1;
            if (req_direct) begin
                rsp_d.bypass = 1'b1;
            end else begin
                rsp_d.exc = judge_code;
                if (judge_code == EXC_NONE) begin
                    rsp_d.pa = {sel_ent.ppn, req_ea[OFF_W-1:0]};
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    xlt_fault_capture u_fault (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (rsp_d.valid && (rsp_d.exc != EXC_NONE)),
        .cap_pc   (req_pc),
        .cap_ea   (req_ea),
        .fault_pc (fault_pc),
        .fault_ea (fault_ea)
    );

    assign rsp_valid  = rsp_q.valid;
    assign rsp_bypass = rsp_q.bypass;
    assign rsp_exc    = rsp_q.exc;
    assign rsp_pa     = rsp_q.pa;

endmodule

// File: rtl/xlt_tlb_unit_chk.sv
module xlt_tlb_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [1:0]  req_kind,
    input logic        req_direct,
    input logic [31:0] req_ea,
    input logic [31:0] req_pc,
    input logic        rsp_valid,
    input logic        rsp_bypass,
    input logic [2:0]  rsp_exc,
    input logic [31:0] rsp_pa,
    input logic [31:0] fault_pc,
    input logic [31:0] fault_ea
);

    assert_lat_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_lat_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_pa_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_exc != 3'd0) |-> (rsp_pa == 32'd0));

    assert_bypass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_direct) |=> (rsp_bypass && rsp_exc == 3'd0 && rsp_pa == 32'd0));

    assert_code_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_exc <= 3'd6);

    assert_miss_fetch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_exc == 3'd1 || rsp_exc == 3'd4) |-> ($past(req_kind) == 2'd0));

    assert_chg_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_exc == 3'd6) |-> ($past(req_kind) == 2'd2));

    assert_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_exc != 3'd0) |-> (fault_pc == $past(req_pc) && fault_ea == $past(req_ea)));

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_exc == 3'd0) |-> ($stable(fault_pc) && $stable(fault_ea)));

endmodule

bind xlt_tlb_unit xlt_tlb_unit_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_kind   (req_kind),
    .req_direct (req_direct),
    .req_ea     (req_ea),
    .req_pc     (req_pc),
    .rsp_valid  (rsp_valid),
    .rsp_bypass (rsp_bypass),
    .rsp_exc    (rsp_exc),
    .rsp_pa     (rsp_pa),
    .fault_pc   (fault_pc),
    .fault_ea   (fault_ea)
);

// File: tb/tb_xlt_tlb_unit.sv
module tb_xlt_tlb_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic        req_direct = 1'b0;
    logic [23:0] req_vsid = '0;
    logic [31:0] req_ea = '0;
    logic [31:0] req_pc = '0;
    logic        rld_valid = 1'b0;
    logic        rld_side = 1'b0;
    logic [3:0]  rld_idx = '0;
    logic [23:0] rld_vsid = '0;
    logic [15:0] rld_pidx = '0;
    logic [19:0] rld_ppn = '0;
    logic [1:0]  rld_prot = '0;
    logic        rld_chg = 1'b0;
    logic        inval_all = 1'b0;
    logic        rsp_valid, rsp_bypass;
    logic [2:0]  rsp_exc;
    logic [31:0] rsp_pa, fault_pc, fault_ea;

    int checks = 0;
    int failures = 0;
    string cur_tag = "R1";
    bit done = 1'b0;

    // Reference state
    bit          m_v   [2][16];
    logic [39:0] m_tag [2][16];
    logic [19:0] m_ppn [2][16];
    logic [1:0]  m_prot[2][16];
    bit          m_chg [2][16];
    logic        e_valid, e_bypass;
    logic [2:0]  e_exc;
    logic [31:0] e_pa, e_fpc, e_fea;

    always #5 clk = ~clk;

    xlt_tlb_unit dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_kind(req_kind), .req_direct(req_direct),
        .req_vsid(req_vsid), .req_ea(req_ea), .req_pc(req_pc),
        .rld_valid(rld_valid), .rld_side(rld_side), .rld_idx(rld_idx),
        .rld_vsid(rld_vsid), .rld_pidx(rld_pidx), .rld_ppn(rld_ppn),
        .rld_prot(rld_prot), .rld_chg(rld_chg), .inval_all(inval_all),
        .rsp_valid(rsp_valid), .rsp_bypass(rsp_bypass), .rsp_exc(rsp_exc),
        .rsp_pa(rsp_pa), .fault_pc(fault_pc), .fault_ea(fault_ea)
    );

    function automatic bit allowed(input logic [1:0] p, input int k);
        if (k == 0) return p == 2'b01 || p == 2'b11;
        if (k == 2) return p == 2'b10 || p == 2'b11;
        return p != 2'b00;
    endfunction

    // Behavioural model, evaluated at every rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < 2; s++)
                for (int i = 0; i < 16; i++) m_v[s][i] = 0;
            e_valid = 0; e_bypass = 0; e_exc = 0; e_pa = 0; e_fpc = 0; e_fea = 0;
        end else begin
            e_valid = req_valid; e_bypass = 0; e_exc = 0; e_pa = 0;
            if (req_valid) begin
                if (req_direct) begin
                    e_bypass = 1;
                end else begin
                    int side;
                    int found;
                    int k;
                    k = int'(req_kind);
                    if (k == 3) k = 1;
                    side = (k == 0) ? 0 : 1;
                    found = -1;
                    for (int i = 15; i >= 0; i--)
                        if (m_v[side][i] && m_tag[side][i] == {req_vsid, req_ea[27:12]}) found = i;
                    if (found < 0) e_exc = (k == 0) ? 3'd1 : (k == 2) ? 3'd3 : 3'd2;
                    else if (!allowed(m_prot[side][found], k)) e_exc = (k == 0) ? 3'd4 : 3'd5;
                    else if (k == 2 && !m_chg[side][found]) e_exc = 3'd6;
                    else e_pa = {m_ppn[side][found], req_ea[11:0]};
                    if (e_exc != 0) begin e_fpc = req_pc; e_fea = req_ea; end
                end
            end
            if (inval_all)
                for (int s = 0; s < 2; s++)
                    for (int i = 0; i < 16; i++) m_v[s][i] = 0;
            if (rld_valid) begin
                m_v[rld_side][rld_idx]    = 1;
                m_tag[rld_side][rld_idx]  = {rld_vsid, rld_pidx};
                m_ppn[rld_side][rld_idx]  = rld_ppn;
                m_prot[rld_side][rld_idx] = rld_prot;
                m_chg[rld_side][rld_idx]  = rld_chg;
            end
        end
        #3;
        if (rst_n && !done) begin
            checks++;
            if (rsp_valid !== e_valid || rsp_bypass !== e_bypass || rsp_exc !== e_exc ||
                rsp_pa !== e_pa || fault_pc !== e_fpc || fault_ea !== e_fea) begin
                failures++;
                $display("FAIL %s: got v=%0d b=%0d exc=%0d pa=%h fpc=%h fea=%h exp v=%0d b=%0d exc=%0d pa=%h fpc=%h fea=%h",
                         cur_tag, rsp_valid, rsp_bypass, rsp_exc, rsp_pa, fault_pc, fault_ea,
                         e_valid, e_bypass, e_exc, e_pa, e_fpc, e_fea);
            end
        end
    end

    task automatic step();
        @(negedge clk);
        req_valid = 0; rld_valid = 0; inval_all = 0;
    endtask

    task automatic set_req(input int k, input logic [23:0] vs, input logic [31:0] ea,
                           input logic [31:0] pc, input bit direct);
        req_valid = 1; req_kind = 2'(k); req_vsid = vs; req_ea = ea; req_pc = pc;
        req_direct = direct;
    endtask

    task automatic set_rld(input bit side, input int idx, input logic [23:0] vs,
                           input logic [15:0] pidx, input logic [19:0] ppn,
                           input logic [1:0] prot, input bit chg);
        rld_valid = 1; rld_side = side; rld_idx = 4'(idx); rld_vsid = vs; rld_pidx = pidx;
        rld_ppn = ppn; rld_prot = prot; rld_chg = chg;
    endtask

    task automatic req(input string t, input int k, input logic [23:0] vs,
                       input logic [31:0] ea, input logic [31:0] pc);
        cur_tag = t; set_req(k, vs, ea, pc, 0); step();
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog: got hang expected completion");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state at the ports
        checks++;
        if (rsp_valid !== 0 || rsp_exc !== 0 || rsp_pa !== 0 || fault_pc !== 0 || fault_ea !== 0) begin
            failures++;
            $display("FAIL R1: got v=%0d exc=%0d pa=%h fpc=%h exp all zero", rsp_valid, rsp_exc, rsp_pa, fault_pc);
        end
        req("R1", 1, 24'h0, 32'h0000_0000, 32'h100);
        // R5: miss codes per kind
        req("R5", 0, 24'h12_3456, 32'h1ABC_D123, 32'h200);
        req("R5", 1, 24'h12_3456, 32'h1ABC_D123, 32'h204);
        req("R5", 2, 24'h12_3456, 32'h1ABC_D123, 32'h208);
        // R2: direct segment bypass, faults held
        cur_tag = "R2"; set_req(1, 24'h1, 32'hFFFF_FFFF, 32'h20C, 1); step();
        // R6: reload then retry hits
        cur_tag = "R6"; set_rld(0, 3, 24'h12_3456, 16'hABCD, 20'hABCDE, 2'b11, 1); step();
        req("R6", 0, 24'h12_3456, 32'h1ABC_D123, 32'h210);
        // R5: upper selector bits ignored
        req("R5", 0, 24'h12_3456, 32'hFABC_D777, 32'h214);
        // R6: same-cycle reload not visible
        cur_tag = "R6"; set_rld(1, 0, 24'h12_3456, 16'hABCD, 20'h11111, 2'b11, 1);
        set_req(1, 24'h12_3456, 32'h0ABC_D000, 32'h218, 0); step();
        req("R6", 1, 24'h12_3456, 32'h0ABC_D004, 32'h21C);
        // R4: data-only page invisible to fetch
        cur_tag = "R4"; set_rld(1, 5, 24'h00_0042, 16'h0007, 20'h22222, 2'b11, 1); step();
        req("R4", 0, 24'h00_0042, 32'h0000_7010, 32'h220);
        req("R4", 1, 24'h00_0042, 32'h0000_7010, 32'h224);
        req("R4", 3, 24'h00_0042, 32'h0000_7018, 32'h226);
        // R5: tag differing only in segment id or only in page index
        req("R5", 1, 24'h00_0043, 32'h0000_7010, 32'h228);
        req("R5", 1, 24'h00_0042, 32'h0000_6010, 32'h22C);
        // R7: protection table
        cur_tag = "R7"; set_rld(1, 6, 24'h7, 16'h0001, 20'h33333, 2'b00, 1); step();
        set_rld(1, 7, 24'h7, 16'h0002, 20'h44444, 2'b01, 1); step();
        set_rld(1, 8, 24'h7, 16'h0003, 20'h55555, 2'b10, 1); step();
        set_rld(0, 6, 24'h7, 16'h0003, 20'h66666, 2'b10, 1); step();
        set_rld(0, 7, 24'h7, 16'h0001, 20'h77777, 2'b00, 1); step();
        for (int k = 0; k < 3; k++) begin
            req("R7", k, 24'h7, 32'h0000_1040, 32'h300 + k);
            req("R7", k, 24'h7, 32'h0000_2040, 32'h310 + k);
            req("R7", k, 24'h7, 32'h0000_3040, 32'h320 + k);
        end
        // R8: changed-bit trap on store only
        cur_tag = "R8"; set_rld(1, 9, 24'h8, 16'h0010, 20'h88888, 2'b11, 0); step();
        req("R8", 2, 24'h8, 32'h0001_0ABC, 32'h400);
        req("R8", 1, 24'h8, 32'h0001_0ABC, 32'h404);
        cur_tag = "R8"; set_rld(1, 9, 24'h8, 16'h0010, 20'h88888, 2'b11, 1); step();
        req("R8", 2, 24'h8, 32'h0001_0ABC, 32'h408);
        // R9: protection beats changed-bit; miss beats all
        cur_tag = "R9"; set_rld(1, 10, 24'h9, 16'h0020, 20'h99999, 2'b01, 0); step();
        req("R9", 2, 24'h9, 32'h0002_0000, 32'h500);
        req("R9", 2, 24'h9, 32'h0003_0000, 32'h504);
        // R12: overwrite index and lowest-index priority
        cur_tag = "R12"; set_rld(1, 10, 24'hA, 16'h0030, 20'hAAAAA, 2'b11, 1); step();
        req("R12", 1, 24'h9, 32'h0002_0000, 32'h600);
        req("R12", 1, 24'hA, 32'h0003_0000, 32'h604);
        cur_tag = "R12"; set_rld(1, 2, 24'hA, 16'h0030, 20'hBBBBB, 2'b11, 1); step();
        req("R12", 1, 24'hA, 32'h0003_0008, 32'h608);
        // R11: invalidate with simultaneous reload
        cur_tag = "R11"; inval_all = 1; set_rld(0, 1, 24'hB, 16'h0040, 20'hCCCCC, 2'b11, 1); step();
        req("R11", 0, 24'hB, 32'h0004_0000, 32'h700);
        req("R11", 0, 24'h12_3456, 32'h1ABC_D123, 32'h704);
        req("R11", 1, 24'hA, 32'h0003_0008, 32'h708);
        // R10: randomized mix, fault registers checked every cycle
        cur_tag = "R10";
        for (int n = 0; n < 400; n++) begin
            int r;
            r = int'($urandom_range(0, 9));
            if (r < 3) set_rld(1'($urandom_range(0, 1)), int'($urandom_range(0, 15)),
                               24'($urandom_range(0, 2)), 16'($urandom_range(0, 3)),
                               20'($urandom), 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
            if (r == 9) inval_all = 1;
            if (r != 8) set_req(int'($urandom_range(0, 3)), 24'($urandom_range(0, 2)),
                                {4'($urandom), 16'($urandom_range(0, 3)), 12'($urandom)},
                                $urandom, (r == 7));
            step();
        end
        step(); step();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule